// File: doc/BRIEF.md
# Multi-Task SPI Auto-Transfer DMA Scheduler

This block is the automatic-mode engine of an SPI controller. It keeps eight independent transfer tasks. Each task owns a buffer in memory (a base address and a byte count), a direction bit, a DMA go bit, a wrap (reload) bit and a pair of software launch bits. A task is launched by a one-cycle pulse on its external trigger line or by a register write that sets both software bits. The engine then moves the task's buffer one byte at a time between a memory port with one cycle of read latency and a byte-level exchange handshake toward the SPI shifter.

Each task raises two events. The halfway event means the lower half of its buffer is ready for software. The end event means the upper half is ready. When wrap mode is set the task keeps its go bit, so software can run it as a ping-pong buffer. Per-task enable and pending bits feed a single interrupt line. A 2-bit chip-select route per task is shown on `cs_sel` while that task runs.

Top module: `spi_task_sched`

## Requirements
- R1: After reset, `irq`, `cs_active`, `xfer_valid`, `mem_re` and `mem_we` are 0, and every register reads 0.
- R2: Global words sit at byte offsets 0x00 (mode, auto bit 17), 0x04 (interrupt enable), 0x08 (pending) and 0x0C (chip-select route). Task n has a 64-byte window at 0x100 + 0x40*n holding control (+0x0), DMA control (+0x4), base (+0x8) and count (+0xC). Every field reads back what was written.
- R3: A task is launched by a pulse on `trig_in[n]` or by a write to its control word with bits 31 and 30 both set. The launch takes effect only while auto mode is on, DMA-control bit 0 (go) is set and the count is nonzero.
- R4: Control bit 0 selects the direction. With 1 (send), byte k of the buffer, at base+k for k = 0..count-1, appears on `xfer_tx` in order. With 0 (receive), 0xFF is sent and each `xfer_rx` byte is written to base+k.
- R5: When count/2 bytes have moved (count >= 2), pending bit 8+n is set (half). After all count bytes, pending bit n is set (end).
- R6: `irq` is the OR over (pending AND enable), registered. Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged.
- R7: Without wrap (DMA-control bit 1 = 0), the go bit clears at the end event. With wrap, go stays set. If both software bits are still set, the task starts again at its base. Writing the control word with both bits 0 stops further restarts.
- R8: When several tasks are waiting, the lowest index is served first.
- R9: A launch for a task that is already waiting or running is ignored.
- R10: While a task runs, `cs_active` is 1 and `cs_sel` holds that task's route field, bits [2n+1:2n] of the route word, stable to the end.
- R11: While auto mode is off, launches are ignored and not remembered, and the engine stays idle.
- R12: Once `xfer_valid` is raised it stays high with `xfer_tx` unchanged until a cycle with `xfer_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (data next cycle) |
| cfg_addr | input | 10 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| trig_in | input | 8 | Per-task external trigger pulses |
| irq | output | 1 | Interrupt line |
| mem_re | output | 1 | Buffer memory read enable |
| mem_we | output | 1 | Buffer memory write enable |
| mem_addr | output | 16 | Buffer memory byte address |
| mem_wdata | output | 8 | Buffer memory write byte |
| mem_rdata | input | 8 | Buffer memory read byte, valid the cycle after `mem_re` |
| xfer_valid | output | 1 | Byte offered to the SPI shifter |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_ready | input | 1 | Shifter accepts the byte and returns `xfer_rx` |
| xfer_rx | input | 8 | Byte shifted in, valid with `xfer_ready` |
| cs_active | output | 1 | A task is running |
| cs_sel | output | 2 | Chip-select route of the running task |

## Verification
The assertions assume that the shifter raises `xfer_ready` only while `xfer_valid` is high. They also assume that memory returns read data exactly one cycle after `mem_re`. The bench model of the shifter raises ready one cycle after it sees an unanswered valid and drops it after the accepting edge. The memory model answers on the next edge. Triggers are single-cycle pulses driven at the falling edge, and register writes to a task are made only while that task is idle.

// File: rtl/spi_task_pkg.sv
package spi_task_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_CAP, ST_XFER, ST_NEXT
  } eng_state_t;

  localparam logic [1:0] W_CTL  = 2'd0;
  localparam logic [1:0] W_DMA  = 2'd1;
  localparam logic [1:0] W_BASE = 2'd2;
  localparam logic [1:0] W_CNT  = 2'd3;

  localparam logic [1:0] G_MODE  = 2'd0;
  localparam logic [1:0] G_IE    = 2'd1;
  localparam logic [1:0] G_IP    = 2'd2;
  localparam logic [1:0] G_ROUTE = 2'd3;

  localparam int AUTO_BIT  = 17;
  localparam int SWEN_BIT  = 31;
  localparam int SWST_BIT  = 30;
  localparam int TASK_BASE = 'h100;
endpackage

// File: rtl/spi_task_arb.sv
module spi_task_arb #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IW'(i);
  end
endmodule

// File: rtl/spi_task_regs.sv
module spi_task_regs
  import spi_task_pkg::*;
#(
  parameter int N      = 8,
  parameter int IW     = 3,
  parameter int AW     = 16,
  parameter int CW     = 16,
  parameter int CSW    = 2,
  parameter int CFG_AW = 10,
  parameter int DW     = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic                  cfg_re,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [DW-1:0]         cfg_wdata,
  output logic [DW-1:0]         cfg_rdata,
  input  logic [N-1:0]          trig_in,
  input  logic                  grant,
  input  logic [IW-1:0]         grant_idx,
  input  logic                  ev_half,
  input  logic                  ev_done,
  input  logic [IW-1:0]         ev_idx,
  input  logic                  busy,
  input  logic [IW-1:0]         cur_idx,
  output logic                  auto_on,
  output logic [N-1:0]          req,
  output logic [N-1:0][AW-1:0]  base,
  output logic [N-1:0][CW-1:0]  cnt,
  output logic [N-1:0]          dirw,
  output logic [N*CSW-1:0]      route,
  output logic                  irq
);
  localparam int PW  = 2 * N;
  localparam int TSW = CFG_AW - 6;

  logic [N-1:0]  sw_en, sw_st, go, rld;
  logic [PW-1:0] ie, ip, ip_clr, ev_set;
  logic [N-1:0]  sw_launch, sw_stop, relaunch, trig_ok;
  logic [CFG_AW-1:0] toff;
  logic [TSW-1:0] tfull;
  logic [IW-1:0]  tsel;
  logic [1:0]     word;
  logic           is_task, t_ok;
  logic [DW-1:0]  rd;
  logic           unused_wd, unused_ad;

  assign unused_wd = ^cfg_wdata;
  assign unused_ad = ^toff;
  assign toff    = cfg_addr - CFG_AW'(TASK_BASE);
  assign tfull   = toff[CFG_AW-1:6];
  assign tsel    = tfull[IW-1:0];
  assign word    = cfg_addr[3:2];
  assign is_task = cfg_addr >= CFG_AW'(TASK_BASE);
  assign t_ok    = is_task && (int'(tfull) < N);

  always_comb begin
    ip_clr = '0;
    if (cfg_we && !is_task && word == G_IP) ip_clr = cfg_wdata[PW-1:0];
    ev_set = '0;
    if (ev_done) ev_set[ev_idx] = 1'b1;
    if (ev_half) ev_set[N + int'(ev_idx)] = 1'b1;
  end

  generate
    for (genvar n = 0; n < N; n++) begin : g_launch
      logic ctl_wr;
      assign ctl_wr       = cfg_we && t_ok && tsel == IW'(n) && word == W_CTL;
      assign sw_launch[n] = ctl_wr && cfg_wdata[SWEN_BIT] && cfg_wdata[SWST_BIT];
      assign sw_stop[n]   = ctl_wr && !cfg_wdata[SWEN_BIT] && !cfg_wdata[SWST_BIT];
      assign relaunch[n]  = ev_done && ev_idx == IW'(n) && rld[n] && sw_en[n] && sw_st[n];
      assign trig_ok[n]   = auto_on && go[n] && cnt[n] != '0 && !req[n] &&
                            (relaunch[n] || ((trig_in[n] || sw_launch[n]) &&
                             !(busy && cur_idx == IW'(n))));
    end
  endgenerate

  always_comb begin
    rd = '0;
    if (!is_task) begin
      case (word)
        G_MODE:  rd[AUTO_BIT] = auto_on;
        G_IE:    rd[PW-1:0] = ie;
        G_IP:    rd[PW-1:0] = ip;
        default: rd[N*CSW-1:0] = route;
      endcase
    end else if (t_ok) begin
      case (word)
        W_CTL:   begin rd[SWEN_BIT] = sw_en[tsel]; rd[SWST_BIT] = sw_st[tsel]; rd[0] = dirw[tsel]; end
        W_DMA:   rd[1:0] = {rld[tsel], go[tsel]};
        W_BASE:  rd[AW-1:0] = base[tsel];
        default: rd[CW-1:0] = cnt[tsel];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      auto_on <= 1'b0; ie <= '0; ip <= '0; route <= '0;
      sw_en <= '0; sw_st <= '0; go <= '0; rld <= '0; dirw <= '0;
      base <= '0; cnt <= '0; req <= '0; irq <= 1'b0; cfg_rdata <= '0;
    end else begin
      if (cfg_we && !is_task) begin
        case (word)
          G_MODE:  auto_on <= cfg_wdata[AUTO_BIT];
          G_IE:    ie <= cfg_wdata[PW-1:0];
          G_ROUTE: route <= cfg_wdata[N*CSW-1:0];
          default: ;
        endcase
      end
      if (cfg_we && t_ok) begin
        case (word)
          W_CTL:   begin sw_en[tsel] <= cfg_wdata[SWEN_BIT]; sw_st[tsel] <= cfg_wdata[SWST_BIT];
                         dirw[tsel] <= cfg_wdata[0]; end
          W_DMA:   begin go[tsel] <= cfg_wdata[0]; rld[tsel] <= cfg_wdata[1]; end
          W_BASE:  base[tsel] <= cfg_wdata[AW-1:0];
          default: cnt[tsel] <= cfg_wdata[CW-1:0];
        endcase
      end
      if (ev_done && !rld[ev_idx]) go[ev_idx] <= 1'b0;
      ip <= (ip & ~ip_clr) | ev_set;
      for (int n = 0; n < N; n++) begin
        if ((grant && grant_idx == IW'(n)) || sw_stop[n]) req[n] <= 1'b0;
        else if (trig_ok[n]) req[n] <= 1'b1;
      end
      irq <= |(ip & ie);
      if (cfg_re) cfg_rdata <= rd;
    end
  end
endmodule

// File: rtl/spi_task_engine.sv
module spi_task_engine
  import spi_task_pkg::*;
#(
  parameter int N   = 8,
  parameter int IW  = 3,
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int CSW = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  auto_on,
  input  logic                  any_req,
  input  logic [IW-1:0]         pick_idx,
  input  logic [N-1:0][AW-1:0]  base,
  input  logic [N-1:0][CW-1:0]  cnt,
  input  logic [N-1:0]          dirw,
  input  logic [N*CSW-1:0]      route,
  output logic                  grant,
  output logic                  ev_half,
  output logic                  ev_done,
  output logic                  busy,
  output logic [IW-1:0]         cur_idx,
  output logic                  mem_re,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_addr,
  output logic [7:0]            mem_wdata,
  input  logic [7:0]            mem_rdata,
  output logic                  xfer_valid,
  output logic [7:0]            xfer_tx,
  input  logic                  xfer_ready,
  input  logic [7:0]            xfer_rx,
  output logic                  cs_active,
  output logic [CSW-1:0]        cs_sel
);
  eng_state_t    st;
  logic [AW-1:0] cur_base;
  logic [CW-1:0] cur_cnt, ofs, half;
  logic          cur_dir;

  assign half    = cur_cnt >> 1;
  assign busy    = st != ST_IDLE;
  assign grant   = st == ST_IDLE && auto_on && any_req;
  assign ev_half = st == ST_NEXT && ofs == half && half != '0;
  assign ev_done = st == ST_NEXT && ofs == cur_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cur_idx <= '0; cur_base <= '0; cur_cnt <= '0; cur_dir <= 1'b0;
      ofs <= '0; mem_re <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      xfer_valid <= 1'b0; xfer_tx <= '0; cs_active <= 1'b0; cs_sel <= '0;
    end else begin
      case (st)
        ST_IDLE: if (grant) begin
          cur_idx   <= pick_idx;
          cur_base  <= base[pick_idx];
          cur_cnt   <= cnt[pick_idx];
          cur_dir   <= dirw[pick_idx];
          cs_sel    <= route[int'(pick_idx)*CSW +: CSW];
          cs_active <= 1'b1;
          ofs       <= '0;
          st        <= ST_ISSUE;
        end
        ST_ISSUE: if (cur_dir) begin
          mem_re   <= 1'b1;
          mem_addr <= cur_base + AW'(ofs);
          st       <= ST_WAIT;
        end else begin
          xfer_valid <= 1'b1;
          xfer_tx    <= 8'hFF;
          st         <= ST_XFER;
        end
        ST_WAIT: begin
          mem_re <= 1'b0;
          st     <= ST_CAP;
        end
        ST_CAP: begin
          xfer_tx    <= mem_rdata;
          xfer_valid <= 1'b1;
          st         <= ST_XFER;
        end
        ST_XFER: if (xfer_ready) begin
          xfer_valid <= 1'b0;
          if (!cur_dir) begin
            mem_we    <= 1'b1;
            mem_addr  <= cur_base + AW'(ofs);
            mem_wdata <= xfer_rx;
          end
          ofs <= ofs + 1'b1;
          st  <= ST_NEXT;
        end
        default: begin
          mem_we <= 1'b0;
          if (ofs == cur_cnt) begin
            cs_active <= 1'b0;
            st        <= ST_IDLE;
          end else begin
            st <= ST_ISSUE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_task_sched.sv
module spi_task_sched #(
  parameter int N      = 8,
  parameter int AW     = 16,
  parameter int CW     = 16,
  parameter int CSW    = 2,
  parameter int CFG_AW = 10,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic [N-1:0]      trig_in,
  output logic              irq,
  output logic              mem_re,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              xfer_valid,
  output logic [7:0]        xfer_tx,
  input  logic              xfer_ready,
  input  logic [7:0]        xfer_rx,
  output logic              cs_active,
  output logic [CSW-1:0]    cs_sel
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic                 auto_on, any_req, grant, ev_half, ev_done, busy;
  logic [IW-1:0]        pick_idx, cur_idx;
  logic [N-1:0]         req, dirw;
  logic [N-1:0][AW-1:0] base;
  logic [N-1:0][CW-1:0] cnt;
  logic [N*CSW-1:0]     route;

  spi_task_regs #(.N(N), .IW(IW), .AW(AW), .CW(CW), .CSW(CSW), .CFG_AW(CFG_AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trig_in(trig_in),
    .grant(grant), .grant_idx(pick_idx), .ev_half(ev_half), .ev_done(ev_done),
    .ev_idx(cur_idx), .busy(busy), .cur_idx(cur_idx), .auto_on(auto_on), .req(req),
    .base(base), .cnt(cnt), .dirw(dirw), .route(route), .irq(irq)
  );

  spi_task_arb #(.N(N), .IW(IW)) u_arb (.req(req), .any(any_req), .idx(pick_idx));

  spi_task_engine #(.N(N), .IW(IW), .AW(AW), .CW(CW), .CSW(CSW)) u_eng (
    .clk(clk), .rst(rst), .auto_on(auto_on), .any_req(any_req), .pick_idx(pick_idx),
    .base(base), .cnt(cnt), .dirw(dirw), .route(route), .grant(grant),
    .ev_half(ev_half), .ev_done(ev_done), .busy(busy), .cur_idx(cur_idx),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .xfer_valid(xfer_valid), .xfer_tx(xfer_tx),
    .xfer_ready(xfer_ready), .xfer_rx(xfer_rx), .cs_active(cs_active), .cs_sel(cs_sel)
  );
endmodule

// File: rtl/spi_task_sched_chk.sv
module spi_task_sched_chk #(
  parameter int CSW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           auto_on,
  input logic           ev_done,
  input logic           mem_re,
  input logic           mem_we,
  input logic           xfer_valid,
  input logic           xfer_ready,
  input logic [7:0]     xfer_tx,
  input logic           cs_active,
  input logic [CSW-1:0] cs_sel
);
  // R4: a byte slot is either a buffer read or a buffer write, never both
  p_mem_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  // R12: an offered byte is held until accepted
  p_hold_byte_r12: assert property (@(posedge clk) disable iff (rst)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_tx));

  // R11: no task starts while auto mode is off
  p_idle_off_r11: assert property (@(posedge clk) disable iff (rst)
    !auto_on && !cs_active |=> !cs_active);

  // R10: the route stays put for the whole run of a task
  p_cs_stable_r10: assert property (@(posedge clk) disable iff (rst)
    cs_active |=> !cs_active || $stable(cs_sel));

  // R5: the end event only happens inside a running task
  p_done_active_r5: assert property (@(posedge clk) disable iff (rst)
    ev_done |-> cs_active);
endmodule

bind spi_task_sched spi_task_sched_chk #(.CSW(CSW)) u_chk (
  .clk(clk), .rst(rst), .auto_on(auto_on), .ev_done(ev_done), .mem_re(mem_re),
  .mem_we(mem_we), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
  .xfer_tx(xfer_tx), .cs_active(cs_active), .cs_sel(cs_sel)
);

// File: tb/spi_task_sched_tb.sv
module spi_task_sched_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [7:0]  trig_in = '0;
  logic        irq, mem_re, mem_we, xfer_valid, cs_active;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, xfer_tx;
  logic [7:0]  mem_rdata = '0;
  logic        xfer_ready = 1'b0;
  logic [7:0]  xfer_rx;
  logic [1:0]  cs_sel;

  int checks = 0, fails = 0;
  logic [7:0] mem [0:255];
  logic [7:0] txlog [0:255];
  int log_n = 0;

  always #4 clk = ~clk;

  spi_task_sched u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trig_in(trig_in), .irq(irq),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .xfer_valid(xfer_valid), .xfer_tx(xfer_tx),
    .xfer_ready(xfer_ready), .xfer_rx(xfer_rx), .cs_active(cs_active), .cs_sel(cs_sel)
  );

  assign xfer_rx = 8'h40 + log_n[7:0];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    if (xfer_valid && !xfer_ready) xfer_ready <= 1'b1;
    else xfer_ready <= 1'b0;
    if (xfer_valid && xfer_ready) begin
      txlog[log_n[7:0]] <= xfer_tx;
      log_n <= log_n + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk); cfg_re = 1'b0; d = cfg_rdata;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); trig_in = m;
    @(negedge clk); trig_in = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_log(input int target);
    for (int i = 0; i < 3000 && log_n < target; i++) @(negedge clk);
    idle(6);
  endtask

  function automatic logic [9:0] tw(input int n, input int w);
    return 10'(32'h100 + n * 64 + w * 4);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check(irq == 0 && cs_active == 0 && xfer_valid == 0 && mem_re == 0 && mem_we == 0,
          "R1 outputs after reset", {27'b0, irq, cs_active, xfer_valid, mem_re, mem_we}, 0);
    rd(10'h008, d); check(d == 0, "R1 pending after reset", d, 0);
    rd(tw(3, 1), d); check(d == 0, "R1 task dma ctl after reset", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(tw(7, 2), 32'h1234); rd(tw(7, 2), d); check(d == 32'h1234, "R2 task7 base readback", d, 32'h1234);
    wr(tw(7, 3), 32'h0009); rd(tw(7, 3), d); check(d == 32'h9, "R2 task7 count readback", d, 9);
    wr(10'h000, 32'h0002_0000); rd(10'h000, d); check(d == 32'h0002_0000, "R2 mode readback", d, 32'h20000);
  endtask

  task automatic t_send_sw();
    logic [31:0] d;
    int s = log_n;
    mem[8'h10] = 8'h11; mem[8'h11] = 8'h22; mem[8'h12] = 8'h33; mem[8'h13] = 8'h44;
    wr(10'h00C, 32'h30); wr(10'h004, 32'h0404);
    wr(tw(2, 2), 32'h10); wr(tw(2, 3), 4); wr(tw(2, 1), 1);
    wr(tw(2, 0), 32'hC000_0001);
    for (int i = 0; i < 100 && !cs_active; i++) @(negedge clk);
    check(cs_active && cs_sel == 2'd3, "R10 route of task2", {30'b0, cs_sel}, 3);
    wait_log(s + 4);
    for (int k = 0; k < 4; k++)
      check(txlog[s + k] == 8'h11 * (k + 1), "R4/R12 send byte order", txlog[s + k], 8'h11 * (k + 1));
    rd(10'h008, d); check(d == 32'h0404, "R5 half and end pending task2", d, 32'h0404);
    check(irq == 1, "R6 irq with enabled pending", irq, 1);
    rd(tw(2, 1), d); check(d == 0, "R7 go cleared without wrap", d, 0);
    wr(10'h008, 32'h0004); rd(10'h008, d); check(d == 32'h0400, "R6 write-1 clears one bit", d, 32'h400);
    idle(2); check(irq == 1, "R6 irq still pending", irq, 1);
    wr(10'h008, 32'h0400); idle(2); check(irq == 0, "R6 irq drops after clear", irq, 0);
  endtask

  task automatic t_recv_trig();
    logic [31:0] d;
    int s = log_n;
    wr(tw(5, 2), 32'h40); wr(tw(5, 3), 3); wr(tw(5, 0), 0); wr(tw(5, 1), 1);
    pulse(8'h20);
    wait_log(s + 3);
    for (int k = 0; k < 3; k++) begin
      check(txlog[s + k] == 8'hFF, "R4 receive sends FF", txlog[s + k], 8'hFF);
      check(mem[8'h40 + k] == 8'(8'h40 + s + k), "R4 receive stores byte", mem[8'h40 + k], 8'(8'h40 + s + k));
    end
    rd(10'h008, d); check(d == 32'h2020, "R5 odd count half and end", d, 32'h2020);
    wr(10'h008, 32'hFFFF);
  endtask

  task automatic t_priority();
    int s = log_n;
    mem[8'h50] = 8'h51; mem[8'h51] = 8'h52; mem[8'h60] = 8'h61; mem[8'h61] = 8'h62;
    wr(tw(1, 2), 32'h50); wr(tw(1, 3), 2); wr(tw(1, 0), 1); wr(tw(1, 1), 1);
    wr(tw(6, 2), 32'h60); wr(tw(6, 3), 2); wr(tw(6, 0), 1); wr(tw(6, 1), 1);
    pulse(8'h42);
    wait_log(s + 4);
    check(txlog[s] == 8'h51 && txlog[s + 1] == 8'h52, "R8 lower task first", {txlog[s], txlog[s + 1]}, 16'h5152);
    check(txlog[s + 2] == 8'h61 && txlog[s + 3] == 8'h62, "R8 higher task next", {txlog[s + 2], txlog[s + 3]}, 16'h6162);
    wr(10'h008, 32'hFFFF);
  endtask

  task automatic t_ignore();
    int s = log_n;
    mem[8'h00] = 8'hA0; mem[8'h01] = 8'hA1; mem[8'h02] = 8'hA2; mem[8'h03] = 8'hA3;
    wr(tw(0, 2), 0); wr(tw(0, 3), 4); wr(tw(0, 0), 1); wr(tw(0, 1), 3);
    pulse(8'h01); idle(4); pulse(8'h01);
    wait_log(s + 4); idle(80);
    check(log_n == s + 4, "R9 trigger during run ignored", log_n - s, 4);
    wr(10'h008, 32'hFFFF);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    int s = log_n, n1;
    mem[8'h20] = 8'hB1; mem[8'h21] = 8'hB2;
    wr(tw(3, 2), 32'h20); wr(tw(3, 3), 2); wr(tw(3, 1), 3);
    wr(tw(3, 0), 32'hC000_0001);
    idle(70);
    check(log_n >= s + 4, "R7 wrap restarts", log_n - s, 4);
    check(txlog[s + 2] == 8'hB1 && txlog[s + 3] == 8'hB2, "R7 restart from base",
          {txlog[s + 2], txlog[s + 3]}, 16'hB1B2);
    wr(tw(3, 0), 32'h1);
    idle(40); n1 = log_n; idle(60);
    check(log_n == n1, "R7 clearing software bits stops", log_n, n1);
    rd(tw(3, 1), d); check(d == 3, "R7 go kept with wrap", d, 3);
    wr(10'h008, 32'hFFFF);
  endtask

  task automatic t_gating();
    int s = log_n;
    wr(10'h000, 0);
    pulse(8'h01); idle(40);
    check(log_n == s && !cs_active, "R11 trigger ignored when auto off", log_n - s, 0);
    wr(10'h000, 32'h0002_0000); idle(40);
    check(log_n == s, "R11 launch not remembered", log_n - s, 0);
    wr(tw(4, 2), 0); wr(tw(4, 3), 0); wr(tw(4, 0), 1); wr(tw(4, 1), 1);
    pulse(8'h10); idle(40);
    check(log_n == s && !cs_active, "R3 zero count not launched", log_n - s, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    idle(4); rst = 1'b0; idle(2);
    t_reset();
    t_regs();
    t_send_sw();
    t_recv_trig();
    t_priority();
    t_ignore();
    t_wrap();
    t_gating();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule